// File: doc/BRIEF.md
# Endpoint Interrupt Flag Register

This block holds the status and interrupt flags of one endpoint in a USB device controller. The endpoint engine sends it single-cycle event pulses for a received SETUP packet, a received OUT packet, a freed IN bank, a NAK answering an OUT or PING token, a transmitted STALL and a CRC error. It also sends the current bank's full and empty status and the endpoint's direction, type and stall request. Firmware sees one 8-bit register. It can read the register, and it can write the register to acknowledge flags.

Each flag has its own enable input. The enabled flags are ORed into one registered interrupt output. Bit 2 depends on direction. On an OUT endpoint it reports a received packet. On an IN endpoint it is a command to discard the most recently written bank. That command sends a one-cycle request to the bank manager and stays pending until the bank manager reports that the bank was discarded.

Top module: `ep_flag_reg`

## Requirements
- R1: While reset is asserted, or with no event since reset and a status that gives bit 5 = 0, the register reads 0x00, and `irq_o` and `kill_req_o` are 0.
- R2: The register layout is: bit 0 transmitter ready, bit 1 stall sent, bit 2 OUT received (kill-bank on IN), bit 3 SETUP received, bit 4 NAK sent, bit 5 read/write allowed, bits 7:6 zero. A flag's event pulse at a clock edge makes that flag read 1 after the edge.
- R3: A write with a 0 in a flag bit clears that flag. A write with a 1 in a flag bit leaves the flag unchanged.
- R4: When a flag's event and a clearing write arrive in the same cycle, the flag reads 1 afterwards.
- R5: Bit 5 is `!bank_full_i` on an IN endpoint (`dir_in_i`=1) and `!bank_empty_i` on an OUT endpoint.
- R6: Bit 5 reads 0 whenever `stall_req_i`, `err_i` or `is_ctrl_i` is 1.
- R7: Bit 3 always reads 0 on an IN endpoint. Bit 0 always reads 0 on an OUT endpoint. On an IN endpoint an OUT-received event does not set bit 2.
- R8: Bit 1 is set by a STALL pulse, and by a CRC-error pulse only on an isochronous (`is_iso_i`=1) OUT endpoint.
- R9: On an IN endpoint, writing 1 to bit 2 makes bit 2 read 1 and pulses `kill_req_o` for one cycle. Bit 2 then stays 1 until `kill_done_i`. Writing 0 to bit 2 has no effect, and writing 1 while a kill is pending sends no second pulse.
- R10: `irq_o` is, one cycle later, the OR over bits 4:0 of (flag AND `ien_i` bit of the same position). On an IN endpoint, bit 2 takes no part in this OR.
- R11: Bit 4 is set by a NAK-sent pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| dir_in_i | input | 1 | 1 = IN endpoint, 0 = OUT endpoint |
| is_ctrl_i | input | 1 | Endpoint is the control endpoint |
| is_iso_i | input | 1 | Endpoint is isochronous |
| bank_full_i | input | 1 | Current bank is full |
| bank_empty_i | input | 1 | Current bank is empty |
| stall_req_i | input | 1 | Stall request active |
| err_i | input | 1 | Endpoint error condition |
| ev_setup_i | input | 1 | SETUP packet received pulse |
| ev_out_i | input | 1 | OUT packet received pulse |
| ev_txfree_i | input | 1 | IN bank freed pulse |
| ev_nak_i | input | 1 | NAK sent on OUT/PING pulse |
| ev_stall_i | input | 1 | STALL handshake sent pulse |
| ev_crc_i | input | 1 | CRC error pulse |
| kill_done_i | input | 1 | Bank manager finished discarding the bank |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Register write data |
| ien_i | input | 5 | Interrupt enables, bit k for register bit k |
| rd_data_o | output | 8 | Register read value |
| irq_o | output | 1 | Registered endpoint interrupt |
| kill_req_o | output | 1 | One-cycle kill-bank request |

## Verification
The assertions assume that `kill_done_i` only answers a pending kill. They also assume that the direction changes only while no flag of the other direction is set, because the readback masks follow direction immediately. The stimulus keeps to these assumptions. It runs all OUT-endpoint cases first, clears every flag, and only then switches to IN. It raises `kill_done_i` only after a kill has been requested. Event pulses last exactly one cycle and are released before the next edge.

// File: rtl/ep_flag_pkg.sv
package ep_flag_pkg;
  localparam int REG_W     = 8;
  localparam int NUM_FLAGS = 5;
  // bit positions decoded by firmware
  localparam int BIT_TXR = 0;
  localparam int BIT_STL = 1;
  localparam int BIT_RXO = 2;
  localparam int BIT_STP = 3;
  localparam int BIT_NAK = 4;
  localparam int BIT_RWA = 5;
endpackage

// File: rtl/ep_flag_bit.sv
module ep_flag_bit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  // set dominates clear so no event is lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end
endmodule

// File: rtl/ep_rwa_calc.sv
module ep_rwa_calc (
  input  logic dir_in_i,
  input  logic bank_full_i,
  input  logic bank_empty_i,
  input  logic stall_req_i,
  input  logic err_i,
  input  logic is_ctrl_i,
  output logic rwa_o
);
  logic bank_ok;
  always_comb begin
    bank_ok = dir_in_i ? !bank_full_i : !bank_empty_i;
    rwa_o   = bank_ok && !stall_req_i && !err_i && !is_ctrl_i;
  end
endmodule

// File: rtl/ep_kill_ctl.sv
module ep_kill_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic done_i,
  output logic pend_o,
  output logic req_o
);
  logic fire;
  assign fire = arm_i && !pend_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_o <= 1'b0;
      req_o  <= 1'b0;
    end else begin
      req_o <= fire;
      if (fire)        pend_o <= 1'b1;
      else if (done_i) pend_o <= 1'b0;
    end
  end
endmodule

// File: rtl/ep_flag_reg.sv
module ep_flag_reg
  import ep_flag_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 dir_in_i,
  input  logic                 is_ctrl_i,
  input  logic                 is_iso_i,
  input  logic                 bank_full_i,
  input  logic                 bank_empty_i,
  input  logic                 stall_req_i,
  input  logic                 err_i,
  input  logic                 ev_setup_i,
  input  logic                 ev_out_i,
  input  logic                 ev_txfree_i,
  input  logic                 ev_nak_i,
  input  logic                 ev_stall_i,
  input  logic                 ev_crc_i,
  input  logic                 kill_done_i,
  input  logic                 wr_en_i,
  input  logic [REG_W-1:0]     wr_data_i,
  input  logic [NUM_FLAGS-1:0] ien_i,
  output logic [REG_W-1:0]     rd_data_o,
  output logic                 irq_o,
  output logic                 kill_req_o
);
  logic [NUM_FLAGS-1:0] set_v, clr_v, q_v, irq_src;
  logic                 rwa, kill_pend;
  logic                 unused_wr_hi;

  assign unused_wr_hi = ^wr_data_i[REG_W-1:NUM_FLAGS];

  // direction-qualified hardware set events
  always_comb begin
    set_v          = '0;
    set_v[BIT_TXR] = ev_txfree_i && dir_in_i;
    set_v[BIT_STL] = ev_stall_i || (ev_crc_i && is_iso_i && !dir_in_i);
    set_v[BIT_RXO] = ev_out_i && !dir_in_i;
    set_v[BIT_STP] = ev_setup_i && !dir_in_i;
    set_v[BIT_NAK] = ev_nak_i;
  end

  assign clr_v = {NUM_FLAGS{wr_en_i}} & ~wr_data_i[NUM_FLAGS-1:0];

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    ep_flag_bit u_bit (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .set_i (set_v[i]),
      .clr_i (clr_v[i]),
      .q_o   (q_v[i])
    );
  end

  ep_kill_ctl u_kill (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .arm_i (wr_en_i && wr_data_i[BIT_RXO] && dir_in_i),
    .done_i(kill_done_i),
    .pend_o(kill_pend),
    .req_o (kill_req_o)
  );

  ep_rwa_calc u_rwa (
    .dir_in_i    (dir_in_i),
    .bank_full_i (bank_full_i),
    .bank_empty_i(bank_empty_i),
    .stall_req_i (stall_req_i),
    .err_i       (err_i),
    .is_ctrl_i   (is_ctrl_i),
    .rwa_o       (rwa)
  );

  always_comb begin
    irq_src          = q_v;
    irq_src[BIT_TXR] = q_v[BIT_TXR] && dir_in_i;
    irq_src[BIT_RXO] = q_v[BIT_RXO] && !dir_in_i;
    irq_src[BIT_STP] = q_v[BIT_STP] && !dir_in_i;

    rd_data_o                  = '0;
    rd_data_o[NUM_FLAGS-1:0]   = irq_src;
    rd_data_o[BIT_RXO]         = dir_in_i ? kill_pend : q_v[BIT_RXO];
    rd_data_o[BIT_RWA]         = rwa;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= |(irq_src & ien_i);
  end
endmodule

module ep_flag_reg_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       dir_in_i,
  input logic       stall_req_i,
  input logic       err_i,
  input logic       is_ctrl_i,
  input logic       ev_nak_i,
  input logic       ev_stall_i,
  input logic       ev_crc_i,
  input logic       kill_done_i,
  input logic       wr_en_i,
  input logic       wr_nak_bit_i,
  input logic [4:0] ien_i,
  input logic [7:0] rd_data_o,
  input logic       irq_o,
  input logic       kill_req_o
);
  // R9
  kill_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kill_req_o |=> !kill_req_o);
  // R9
  kill_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_in_i && rd_data_o[2] && !kill_done_i) |=> (!dir_in_i || rd_data_o[2]));
  // R6
  rwa_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_req_i || err_i || is_ctrl_i) |-> !rd_data_o[5]);
  // R7
  setup_in_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dir_in_i |-> !rd_data_o[3]);
  // R7
  txr_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dir_in_i |-> !rd_data_o[0]);
  // R4
  nak_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_nak_i |=> rd_data_o[4]);
  // R3
  wr_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_nak_bit_i && !ev_nak_i && !rd_data_o[4]) |=> !rd_data_o[4]);
  // R8
  stl_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ev_stall_i && !ev_crc_i && !wr_en_i) |=> $stable(rd_data_o[1]));
  // R2
  hi_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[7:6] == 2'b00);
  // R10
  irq_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ien_i == 5'b0) |=> !irq_o);
endmodule

bind ep_flag_reg ep_flag_reg_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .dir_in_i    (dir_in_i),
  .stall_req_i (stall_req_i),
  .err_i       (err_i),
  .is_ctrl_i   (is_ctrl_i),
  .ev_nak_i    (ev_nak_i),
  .ev_stall_i  (ev_stall_i),
  .ev_crc_i    (ev_crc_i),
  .kill_done_i (kill_done_i),
  .wr_en_i     (wr_en_i),
  .wr_nak_bit_i(wr_data_i[4]),
  .ien_i       (ien_i),
  .rd_data_o   (rd_data_o),
  .irq_o       (irq_o),
  .kill_req_o  (kill_req_o)
);

// File: tb/ep_flag_reg_test.sv
module ep_flag_reg_test;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic dir_in = 1'b0, is_ctrl = 1'b0, is_iso = 1'b0;
  logic bank_full = 1'b0, bank_empty = 1'b1, stall_req = 1'b0, err = 1'b0;
  logic ev_setup = 1'b0, ev_out = 1'b0, ev_txfree = 1'b0, ev_nak = 1'b0;
  logic ev_stall = 1'b0, ev_crc = 1'b0, kill_done = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [4:0] ien = 5'h00;
  logic [7:0] rd_data;
  logic irq, kill_req;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  typedef struct {
    string      req;
    logic [7:0] rd_exp;
    bit         irq_chk;
    logic       irq_exp;
    bit         kill_chk;
    logic       kill_exp;
  } item_t;
  item_t sb_q[$];

  always #2 clk = ~clk;

  ep_flag_reg uut (
    .clk_i(clk), .rst_ni(rst_ni), .dir_in_i(dir_in), .is_ctrl_i(is_ctrl),
    .is_iso_i(is_iso), .bank_full_i(bank_full), .bank_empty_i(bank_empty),
    .stall_req_i(stall_req), .err_i(err), .ev_setup_i(ev_setup),
    .ev_out_i(ev_out), .ev_txfree_i(ev_txfree), .ev_nak_i(ev_nak),
    .ev_stall_i(ev_stall), .ev_crc_i(ev_crc), .kill_done_i(kill_done),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .ien_i(ien),
    .rd_data_o(rd_data), .irq_o(irq), .kill_req_o(kill_req)
  );

  // monitor: compare after each edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        checks++;
        if (rd_data !== it.rd_exp) begin
          errors++;
          $display("FAIL %s rd_data act=%h exp=%h", it.req, rd_data, it.rd_exp);
        end
        if (it.irq_chk) begin
          checks++;
          if (irq !== it.irq_exp) begin
            errors++;
            $display("FAIL %s irq act=%b exp=%b", it.req, irq, it.irq_exp);
          end
        end
        if (it.kill_chk) begin
          checks++;
          if (kill_req !== it.kill_exp) begin
            errors++;
            $display("FAIL %s kill_req act=%b exp=%b", it.req, kill_req, it.kill_exp);
          end
        end
      end
    end
  end

  // driver: inputs already set at negedge; push expectation, advance, drop pulses
  task automatic cyc(input string req, input logic [7:0] rd_exp,
                     input bit ic, input logic ie, input bit kc, input logic ke);
    item_t it;
    it.req = req; it.rd_exp = rd_exp;
    it.irq_chk = ic; it.irq_exp = ie; it.kill_chk = kc; it.kill_exp = ke;
    sb_q.push_back(it);
    @(negedge clk);
    ev_setup = 0; ev_out = 0; ev_txfree = 0; ev_nak = 0;
    ev_stall = 0; ev_crc = 0; kill_done = 0; wr_en = 0;
  endtask

  task automatic rd(input string req, input logic [7:0] rd_exp);
    cyc(req, rd_exp, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    cyc("R1 reset", 8'h00, 1'b1, 1'b0, 1'b1, 1'b0);
    rst_ni = 1'b1;
    cyc("R1 idle", 8'h00, 1'b1, 1'b0, 1'b1, 1'b0);
    // OUT endpoint
    ev_setup = 1;          rd("R2 setup set", 8'h08);
    wr(8'hFF);             rd("R3 write one no effect", 8'h08);
    wr(8'hF7);             rd("R3 write zero clears", 8'h00);
    ev_out = 1; ev_nak = 1; ev_stall = 1;
                           rd("R2 R11 R8 multi set", 8'h16);
    wr(8'h00); ev_out = 1; rd("R4 set wins", 8'h04);
    ev_txfree = 1;         rd("R7 txr masked on out", 8'h04);
    wr(8'h00);             rd("R3 clear all", 8'h00);
    ev_crc = 1;            rd("R8 crc non-iso ignored", 8'h00);
    is_iso = 1; ev_crc = 1;rd("R8 crc iso out", 8'h02);
    wr(8'h00); is_iso = 0; rd("R3 clear stall", 8'h00);
    bank_empty = 0;        rd("R5 out not empty", 8'h20);
    stall_req = 1;         rd("R6 stall request", 8'h00);
    stall_req = 0; err = 1;rd("R6 error", 8'h00);
    err = 0; is_ctrl = 1;  rd("R6 control", 8'h00);
    is_ctrl = 0;           rd("R5 restored", 8'h20);
    ien = 5'b01000; ev_setup = 1;
    cyc("R10 irq lags flag", 8'h28, 1'b1, 1'b0, 1'b0, 1'b0);
    cyc("R10 irq asserted", 8'h28, 1'b1, 1'b1, 1'b0, 1'b0);
    wr(8'hF7);
    cyc("R10 irq from prior state", 8'h20, 1'b1, 1'b1, 1'b0, 1'b0);
    cyc("R10 irq drops", 8'h20, 1'b1, 1'b0, 1'b0, 1'b0);
    ien = 5'b00000; ev_nak = 1;
    rd("R11 nak", 8'h30);
    cyc("R10 disabled", 8'h30, 1'b1, 1'b0, 1'b0, 1'b0);
    wr(8'h00);             rd("R3 clear nak", 8'h20);
    // IN endpoint
    dir_in = 1;            rd("R5 in not full", 8'h20);
    bank_full = 1;         rd("R5 in full", 8'h00);
    ev_setup = 1;          rd("R7 setup masked on in", 8'h00);
    ev_txfree = 1;         rd("R2 txr on in", 8'h01);
    ev_out = 1;            rd("R7 out ignored on in", 8'h01);
    wr(8'h05);
    cyc("R9 kill write", 8'h05, 1'b0, 1'b0, 1'b1, 1'b1);
    cyc("R9 kill pulse single", 8'h05, 1'b0, 1'b0, 1'b1, 1'b0);
    wr(8'hFA);
    cyc("R9 write zero keeps kill", 8'h04, 1'b0, 1'b0, 1'b1, 1'b0);
    kill_done = 1;         rd("R9 kill done", 8'h00);
    wr(8'h04);
    cyc("R9 kill again", 8'h04, 1'b0, 1'b0, 1'b1, 1'b1);
    wr(8'h04);
    cyc("R9 rewrite while pending", 8'h04, 1'b0, 1'b0, 1'b1, 1'b0);
    ien = 5'b00100;
    cyc("R10 kill bit no irq", 8'h04, 1'b0, 1'b0, 1'b0, 1'b0);
    cyc("R10 kill bit no irq", 8'h04, 1'b1, 1'b0, 1'b0, 1'b0);
    kill_done = 1;         rd("R9 kill done again", 8'h00);
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule